// File: doc/BRIEF.md
# Address-Error Exception Frame Writer

This block lays down the exception record that a processor core leaves on its supervisor stack when an access lands on an odd address. A single start pulse captures everything the record needs: the faulting address, the opcode word, the status register, the program counter, the supervisor flag, the read/write direction and whether the access was an instruction fetch. It also captures a layout level and the current stack pointer. The block then lowers the stack pointer once by the full size of the record and emits the record as a stream of 16-bit stores, from the lowest address to the highest.

Two layouts are supported. Level 0 is a compact seven-word record, followed by two quiet cycles. Level 1 is a 29-word record. Its lowest four words are the common frame: status register, program counter and a format/vector word carrying format 8 and vector 3. Above them sits a 25-word extension with a status word, the fault address, the opcode and zero-filled buffers. Stores leave through a valid/ready port. The block holds address and data unchanged while `wr_ready` is low and advances only on a cycle where both `wr_valid` and `wr_ready` are high. A second start that arrives while a record is still in progress is a double fault: the block stops and raises `halt`, which only reset clears.

Top module: `aerr_frame_builder`

## Requirements
- R1: After reset `wr_valid`, `busy`, `done` and `halt` are 0 and `sp_out` is 0.
- R2: A start accepted while the block is idle or in its done cycle captures all inputs. From the next cycle, `sp_out` equals `sp_in` minus 14 (level 0) or minus 58 (level 1). Input changes after that edge do not alter the record.
- R3: A level-0 record is 7 stores at `sp_out`+0, +2, …, +12. Their data, in order, is: mode word, fault address bits 31:16, fault address bits 15:0, opcode, status register, PC bits 31:16, PC bits 15:0.
- R4: Level-0 mode word: bits 15:5 = opcode bits 15:5; bit 4 = 1 for a read; bit 3 = 1 for a data (non-instruction) access; bit 2 = supervisor; bits 1:0 = 2 for an instruction access and 1 for a data access.
- R5: A level-1 record is 29 stores at `sp_out`+0 … +56. The first four, in order, are: status register, PC high, PC low, format/vector word 0x800C. Next come the status word, fault address high, fault address low and five zero words. Then the opcode, one zero word and fifteen zero words.
- R6: Level-1 status word: bit 13 = 1 for a data access; bit 8 = 1 for a read; bit 2 = supervisor; bits 1:0 as in R4; all other bits 0.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values; the next store appears only after a cycle with both high.
- R8: After the last level-0 store is accepted, `busy` stays 1 with no store for 2 cycles and then `done` is 1 for one cycle. After the last level-1 store, `done` is 1 in the next cycle.
- R9: A start while `busy` is 1 sets `halt`. It ends all stores and `done`, and `halt` stays 1 with further starts ignored until reset.
- R10: `busy` is 1 exactly while stores or the level-0 quiet cycles are pending; `wr_valid` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a record (or double fault if busy) |
| level | input | 1 | 0 = compact layout, 1 = long layout |
| fault_addr | input | 32 | Faulting access address |
| opcode | input | 16 | Opcode word of the faulting instruction |
| sr | input | 16 | Status register to save |
| pc | input | 32 | Program counter to save |
| sup | input | 1 | Access made in supervisor mode |
| is_read | input | 1 | 1 = read access, 0 = write |
| is_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| sp_in | input | 32 | Stack pointer before the record |
| wr_valid | output | 1 | Store request valid |
| wr_ready | input | 1 | Store accepted by memory side |
| wr_addr | output | 32 | Store byte address |
| wr_data | output | 16 | Store data word |
| sp_out | output | 32 | Stack pointer after the record |
| busy | output | 1 | Record in progress |
| done | output | 1 | One-cycle completion pulse |
| halt | output | 1 | Double fault seen, sticky until reset |

## Verification
The bench builds the block with its default parameters: vector number 3, format 8 and two quiet cycles. It therefore checks the literal 0x800C format/vector word and the exact two-cycle gap of R8. With these values the bench reaches both layouts under continuous, one-in-three-stalled and alternating `wr_ready` patterns. It also covers back-to-back records started in the done cycle, input changes after capture, and a double fault raised mid-record followed by a start that must be ignored.

// File: rtl/aerr_pkg.sv
package aerr_pkg;
  localparam int IDX_W       = 5;
  localparam int SHORT_WORDS = 7;
  localparam int LONG_WORDS  = 29;
  localparam int SHORT_BYTES = SHORT_WORDS * 2;
  localparam int LONG_BYTES  = LONG_WORDS * 2;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_TAIL, ST_DONE} aerr_state_e;

  typedef struct packed {
    logic [31:0] fault;
    logic [15:0] opcode;
    logic [15:0] sr;
    logic [31:0] pc;
    logic        sup;
    logic        is_read;
    logic        is_instr;
    logic        level;
  } aerr_ctx_t;

  // compact layout: opcode upper bits, read, non-instruction, supervisor, access kind
  function automatic logic [15:0] short_mode(aerr_ctx_t c);
    return {c.opcode[15:5], c.is_read, ~c.is_instr, c.sup, c.is_instr, ~c.is_instr};
  endfunction

  // long layout status word
  function automatic logic [15:0] long_status(aerr_ctx_t c);
    return {2'b00, ~c.is_instr, 4'b0000, c.is_read, 5'b00000, c.sup, c.is_instr, ~c.is_instr};
  endfunction
endpackage

// File: rtl/aerr_word_mux.sv
module aerr_word_mux
  import aerr_pkg::*;
#(
  parameter logic [15:0] FV_WORD = 16'h800C
) (
  input  aerr_ctx_t        ctx,
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      data
);
  always_comb begin
    data = 16'h0000;
    if (!ctx.level) begin
      case (idx)
        5'd0: data = short_mode(ctx);
        5'd1: data = ctx.fault[31:16];
        5'd2: data = ctx.fault[15:0];
        5'd3: data = ctx.opcode;
        5'd4: data = ctx.sr;
        5'd5: data = ctx.pc[31:16];
        5'd6: data = ctx.pc[15:0];
        default: data = 16'h0000;
      endcase
    end else begin
      case (idx)
        5'd0:  data = ctx.sr;
        5'd1:  data = ctx.pc[31:16];
        5'd2:  data = ctx.pc[15:0];
        5'd3:  data = FV_WORD;
        5'd4:  data = long_status(ctx);
        5'd5:  data = ctx.fault[31:16];
        5'd6:  data = ctx.fault[15:0];
        5'd12: data = ctx.opcode;
        default: data = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/aerr_seq.sv
module aerr_seq
  import aerr_pkg::*;
#(
  parameter int TAIL_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             level,
  input  logic             ready,
  output logic             accept,
  output aerr_state_e      state,
  output logic [IDX_W-1:0] idx,
  output logic             halted
);
  localparam int TW = $clog2(TAIL_CYCLES + 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(LONG_WORDS - 1);

  logic          lvl_q;
  logic [TW-1:0] tcnt;
  logic          in_frame;
  logic          last_word;

  assign in_frame  = (state == ST_WRITE) || (state == ST_TAIL);
  assign accept    = start && !halted && !in_frame;
  assign last_word = idx == (lvl_q ? LAST_LONG : LAST_SHORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      lvl_q  <= 1'b0;
      tcnt   <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (start && in_frame) begin
        halted <= 1'b1;
        state  <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE, ST_DONE: begin
            if (accept) begin
              state <= ST_WRITE;
              idx   <= '0;
              lvl_q <= level;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_WRITE: begin
            if (ready) begin
              if (last_word) begin
                if (lvl_q) begin
                  state <= ST_DONE;
                end else begin
                  state <= ST_TAIL;
                  tcnt  <= TW'(TAIL_CYCLES - 1);
                end
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
          ST_TAIL: begin
            if (tcnt == '0) state <= ST_DONE;
            else            tcnt  <= tcnt - 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/aerr_frame_builder.sv
module aerr_frame_builder
  import aerr_pkg::*;
#(
  parameter int VECTOR_NUM  = 3,
  parameter int LONG_FMT    = 8,
  parameter int TAIL_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        level,
  input  logic [31:0] fault_addr,
  input  logic [15:0] opcode,
  input  logic [15:0] sr,
  input  logic [31:0] pc,
  input  logic        sup,
  input  logic        is_read,
  input  logic        is_instr,
  input  logic [31:0] sp_in,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [31:0] wr_addr,
  output logic [15:0] wr_data,
  output logic [31:0] sp_out,
  output logic        busy,
  output logic        done,
  output logic        halt
);
  localparam logic [15:0] FV_WORD = 16'((LONG_FMT << 12) | (VECTOR_NUM * 4));

  aerr_ctx_t        ctx_q;
  aerr_state_e      state;
  logic [IDX_W-1:0] idx;
  logic             accept;
  logic [31:0]      sp_q;

  aerr_seq #(.TAIL_CYCLES(TAIL_CYCLES)) i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .level  (level),
    .ready  (wr_ready),
    .accept (accept),
    .state  (state),
    .idx    (idx),
    .halted (halt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
      sp_q  <= '0;
    end else if (accept) begin
      ctx_q <= '{fault: fault_addr, opcode: opcode, sr: sr, pc: pc,
                 sup: sup, is_read: is_read, is_instr: is_instr, level: level};
      sp_q  <= sp_in - (level ? 32'(LONG_BYTES) : 32'(SHORT_BYTES));
    end
  end

  aerr_word_mux #(.FV_WORD(FV_WORD)) i_mux (
    .ctx  (ctx_q),
    .idx  (idx),
    .data (wr_data)
  );

  assign wr_valid = state == ST_WRITE;
  assign wr_addr  = sp_q + {26'd0, idx, 1'b0};
  assign sp_out   = sp_q;
  assign busy     = (state == ST_WRITE) || (state == ST_TAIL);
  assign done     = state == ST_DONE;
endmodule

// File: rtl/aerr_frame_checker.sv
module aerr_frame_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [15:0] wr_data,
  input logic [31:0] sp_out,
  input logic        busy,
  input logic        done,
  input logic        halt
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !start |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !wr_valid && !done && !busy);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr - sp_out) < 32'd58);

  p_sp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sp_out));
endmodule

bind aerr_frame_builder aerr_frame_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .sp_out   (sp_out),
  .busy     (busy),
  .done     (done),
  .halt     (halt)
);

// File: tb/test_aerr_frame_builder.sv
module test_aerr_frame_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, level = 1'b0, sup = 1'b0, is_read = 1'b0, is_instr = 1'b0;
  logic [31:0] fault_addr = '0, pc = '0, sp_in = '0;
  logic [15:0] opcode = '0, sr = '0;
  logic        wr_ready = 1'b1;
  logic        wr_valid, busy, done, halt;
  logic [31:0] wr_addr, sp_out;
  logic [15:0] wr_data;

  int total = 0, bad = 0, cyc = 0, rmode = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  aerr_frame_builder #(.VECTOR_NUM(3), .LONG_FMT(8), .TAIL_CYCLES(2)) i_aerr_frame_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level), .fault_addr(fault_addr),
    .opcode(opcode), .sr(sr), .pc(pc), .sup(sup), .is_read(is_read), .is_instr(is_instr),
    .sp_in(sp_in), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .sp_out(sp_out), .busy(busy), .done(done), .halt(halt));

  // reference model: 0 idle, 1 storing, 2 quiet, 3 done
  typedef struct { logic [31:0] a; logic [15:0] d; string tag; } ent_t;
  ent_t q[$];
  int m_st = 0, m_tail = 0;
  bit m_halt = 0, m_lvl = 0;
  logic [31:0] m_sp = '0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic void push(logic [15:0] d, string tag);
    ent_t e;
    e.a = m_sp + 32'(2 * q.size());
    e.d = d;
    e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic void build();
    logic [15:0] kind = is_instr ? 16'h0002 : 16'h0001;
    m_lvl = level;
    q.delete();
    if (!level) begin
      m_sp = sp_in - 32'd14;
      push({opcode[15:5], 5'b0} | (is_read ? 16'h0010 : 16'h0) | (is_instr ? 16'h0 : 16'h0008)
           | (sup ? 16'h0004 : 16'h0) | kind, "R4");
      push(fault_addr[31:16], "R3"); push(fault_addr[15:0], "R3");
      push(opcode, "R3"); push(sr, "R3");
      push(pc[31:16], "R3"); push(pc[15:0], "R3");
    end else begin
      m_sp = sp_in - 32'd58;
      push(sr, "R5"); push(pc[31:16], "R5"); push(pc[15:0], "R5"); push(16'h800C, "R5");
      push((is_instr ? 16'h0 : 16'h2000) | (is_read ? 16'h0100 : 16'h0) | (sup ? 16'h0004 : 16'h0) | kind, "R6");
      push(fault_addr[31:16], "R5"); push(fault_addr[15:0], "R5");
      for (int k = 0; k < 5; k++) push(16'h0, "R5");
      push(opcode, "R5");
      for (int k = 0; k < 16; k++) push(16'h0, "R5");
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_halt = 0; m_sp = '0; q.delete();
    end else if (m_halt) begin
    end else if (start && (m_st == 1 || m_st == 2)) begin
      m_halt = 1; m_st = 0; q.delete();
    end else begin
      case (m_st)
        0, 3: if (start) begin build(); m_st = 1; end else m_st = 0;
        1: if (wr_ready) begin
             void'(q.pop_front());
             if (q.size() == 0) begin
               if (!m_lvl) begin m_st = 2; m_tail = 2; end
               else m_st = 3;
             end
           end
        2: begin m_tail--; if (m_tail == 0) m_st = 3; end
        default: m_st = 0;
      endcase
    end
  end

  // ready pattern and per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == (m_st == 1 || m_st == 2), "R10 busy", 32'(busy), 32'(m_st == 1 || m_st == 2));
      chk(done == (m_st == 3), "R8 done", 32'(done), 32'(m_st == 3));
      chk(wr_valid == (m_st == 1), "R7 valid", 32'(wr_valid), 32'(m_st == 1));
      chk(halt == m_halt, "R9 halt", 32'(halt), 32'(m_halt));
      chk(sp_out == m_sp, "R2 sp", sp_out, m_sp);
      if (m_st == 1 && q.size() > 0) begin
        chk(wr_addr == q[0].a, {q[0].tag, " addr"}, wr_addr, q[0].a);
        chk(wr_data == q[0].d, {q[0].tag, " data"}, 32'(wr_data), 32'(q[0].d));
      end
    end
    case (rmode)
      1: wr_ready = (cyc % 3) != 0;
      2: wr_ready = cyc[0];
      default: wr_ready = 1'b1;
    endcase
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid && !busy && !done && !halt && sp_out == 0, "R1 reset",
        {wr_valid, busy, done, halt, sp_out[27:0]}, 32'h0);
  endtask

  task automatic frame(bit lv, logic [31:0] fa, logic [15:0] op, logic [15:0] s,
                       logic [31:0] p, bit sv, bit rd, bit ins, logic [31:0] sp);
    level = lv; fault_addr = fa; opcode = op; sr = s; pc = p;
    sup = sv; is_read = rd; is_instr = ins; sp_in = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: scramble inputs after capture
    fault_addr = ~fa; opcode = ~op; sr = ~s; pc = ~p; sup = ~sv; is_read = ~rd;
    is_instr = ~ins; level = ~lv; sp_in = sp + 32'h100;
    for (int w = 0; w < 400 && !done; w++) @(negedge clk);
    chk(done, "R8 completion", 32'(done), 32'h1);
  endtask

  initial begin
    do_reset();
    rmode = 0;
    frame(1'b0, 32'h0012_3457, 16'h4E75, 16'h2704, 32'h00FC_0A10, 1'b1, 1'b1, 1'b1, 32'h0000_8000);
    rmode = 1;
    frame(1'b0, 32'hDEAD_BEEF, 16'h3081, 16'h0010, 32'h0001_2340, 1'b0, 1'b0, 1'b0, 32'h0004_0002);
    rmode = 2;
    frame(1'b1, 32'h0000_1001, 16'h2010, 16'h2000, 32'h0000_0400, 1'b1, 1'b1, 1'b0, 32'h0000_7FFE);
    rmode = 1;
    // back-to-back: started in the done cycle
    frame(1'b1, 32'h8765_4321, 16'hA5C3, 16'hFFFF, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 32'h0010_0000);
    rmode = 0;
    frame(1'b0, 32'h0000_0003, 16'hFFE0, 16'h8000, 32'h0000_0002, 1'b1, 1'b0, 1'b1, 32'h0000_0100);
    // R9: double fault
    rmode = 1;
    level = 1'b1; sp_in = 32'h0000_2000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(halt, "R9 halt raised", 32'(halt), 32'h1);
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(halt && !wr_valid && !done, "R9 start ignored", {halt, wr_valid, done}, 32'h4);
    rmode = 0;
    do_reset();
    frame(1'b1, 32'h0000_0005, 16'h1234, 16'h0700, 32'h0000_0800, 1'b1, 1'b0, 1'b0, 32'h0000_1000);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule